// File: doc/BRIEF.md
# Dual-Source Reset Sequencer

This block merges two reset sources into one synchronous internal reset for a line-interface device. The first source is an asynchronous active-low reset pin. It passes through a two-flop synchroniser and a minimum-width filter, so short glitches on the pin are rejected. The second source is software: any write to the reset register address. Either source starts an internal reset pulse of fixed length. While the pulse is high, every line output-enable is forced off.

When the pulse ends, a settling window starts. The ready flag rises only after that window has run to the end. Until then, register writes other than the reset write are dropped. One configuration bit, the line-mode bit, is held in this block. A software reset leaves it unchanged. A hardware reset returns it to its default value.

Every interval is counted on the master clock, and each length is a parameter. The write port is plain control. A write is accepted in any cycle where `wr_en` is high, and there is no back-pressure. Nothing flows through the block as a stream.

Top module: `dual_reset_seq`

## Requirements
- R1: A write with `wr_addr` equal to RST_ADDR (default 0x04) and any `wr_data` raises `core_rst` at the next clock edge. `core_rst` then stays high for exactly PULSE_CYC cycles (default 3).
- R2: If `hw_rst_n` is seen low on fewer than HW_MIN_CYC consecutive clock edges, the pulse is ignored. `core_rst`, `ready` and `mode_bit` do not change.
- R3: If `hw_rst_n` is seen low on HW_MIN_CYC or more consecutive edges, `core_rst` is asserted after the two synchroniser stages and the filter. It stays high while the filter sees the pin low, and for PULSE_CYC cycles after that.
- R4: While `core_rst` is high, `line_oe` is all zeros. Otherwise `line_oe` equals `oe_req`.
- R5: A software reset leaves `mode_bit` unchanged.
- R6: A hardware reset sets `mode_bit` to MODE_DEF (default 0).
- R7: `ready` is low from power-up and during every reset. It rises exactly SETTLE_CYC cycles (default 103) after `core_rst` falls, and stays high until the next reset.
- R8: A write to MODE_ADDR (default 0x20) loads `mode_bit` from `wr_data` bit 0 only while `ready` is high. The same write before `ready` has no effect.
- R9: A software reset write that arrives during the reset pulse or the settling window restarts the full pulse and settling sequence.
- R10: Writes to any address other than RST_ADDR and MODE_ADDR change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all intervals are counted on it |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| oe_req | input | N_OE | Output-enable requests from the datapath |
| core_rst | output | 1 | Synchronous active-high internal reset |
| line_oe | output | N_OE | Output enables, gated off during reset |
| mode_bit | output | 1 | Line-mode configuration bit |
| ready | output | 1 | High when register access is allowed |

## Verification
The assertions assume one thing about the inputs: the master clock keeps running while the pin is low. Because of this, the filter output (the value that disables the properties) always settles within a few cycles of a pin edge. They also assume that `hw_rst_n` is held low from time zero, so the first cycles start in a hardware reset. The stimulus follows both assumptions. It holds the pin low from the first clock and changes the pin and the write inputs only on falling clock edges. It also spaces the hardware pulses far enough apart that each one is either fully rejected or fully detected.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    PH_HOLD   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_OPEN   = 2'd2
  } phase_t;
endpackage

// File: rtl/rstseq_pin_filter.sv
// Two-flop synchroniser followed by a minimum-width low detector.
module rstseq_pin_filter #(
  parameter int HW_MIN_CYC = 1
) (
  input  logic clk,
  input  logic pin_n,
  output logic hw_det
);
  logic [1:0]            meta;
  logic [HW_MIN_CYC-1:0] win;

  always_ff @(posedge clk) begin
    meta <= {meta[0], pin_n};
  end

  generate
    if (HW_MIN_CYC == 1) begin : g_single
      always_ff @(posedge clk) win <= meta[1];
    end else begin : g_window
      always_ff @(posedge clk) win <= {win[HW_MIN_CYC-2:0], meta[1]};
    end
  endgenerate

  // Reset is seen only once every sample in the window is low.
  assign hw_det = ~|win;
endmodule

// File: rtl/rstseq_phase_ctl.sv
// Reset pulse, settling window and ready flag.
module rstseq_phase_ctl
  import rstseq_pkg::*;
#(
  parameter int PULSE_CYC  = 3,
  parameter int SETTLE_CYC = 103
) (
  input  logic clk,
  input  logic hw_det,
  input  logic sw_kick,
  output logic core_rst,
  output logic ready
);
  localparam int MAX_CYC = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             rst_q;
  logic             rdy_q;

  always_ff @(posedge clk) begin
    if (hw_det || sw_kick) begin
      phase <= PH_HOLD;
      cnt   <= '0;
      rst_q <= 1'b1;
      rdy_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          if (cnt == PULSE_LAST) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
            rst_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            phase <= PH_OPEN;
            cnt   <= '0;
            rdy_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_OPEN: ;
        default: begin
          phase <= PH_HOLD;
          cnt   <= '0;
          rst_q <= 1'b1;
          rdy_q <= 1'b0;
        end
      endcase
    end
  end

  assign core_rst = rst_q;
  assign ready    = rdy_q;
endmodule

// File: rtl/rstseq_mode_keep.sv
// Line-mode bit: cleared only by hardware reset, writable only when ready.
module rstseq_mode_keep #(
  parameter logic MODE_DEF = 1'b0
) (
  input  logic clk,
  input  logic hw_det,
  input  logic mode_wr,
  input  logic mode_d,
  output logic mode_q
);
  always_ff @(posedge clk) begin
    if (hw_det)       mode_q <= MODE_DEF;
    else if (mode_wr) mode_q <= mode_d;
  end
endmodule

// File: rtl/dual_reset_seq.sv
module dual_reset_seq #(
  parameter int          PULSE_CYC  = 3,
  parameter int          SETTLE_CYC = 103,
  parameter int          HW_MIN_CYC = 1,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter int          N_OE       = 8,
  parameter int          MODE_POS   = 0,
  parameter logic [7:0]  RST_ADDR   = 8'h04,
  parameter logic [7:0]  MODE_ADDR  = 8'h20,
  parameter logic        MODE_DEF   = 1'b0
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_OE-1:0]   oe_req,
  output logic              core_rst,
  output logic [N_OE-1:0]   line_oe,
  output logic              mode_bit,
  output logic              ready
);
  localparam logic [ADDR_W-1:0] RST_A  = ADDR_W'(RST_ADDR);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

  logic hw_det;
  logic sw_kick;
  logic mode_wr;

  assign sw_kick = wr_en && (wr_addr == RST_A);
  assign mode_wr = wr_en && (wr_addr == MODE_A) && ready;

  rstseq_pin_filter #(.HW_MIN_CYC(HW_MIN_CYC)) u_filter (
    .clk    (clk),
    .pin_n  (hw_rst_n),
    .hw_det (hw_det)
  );

  rstseq_phase_ctl #(.PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_phase (
    .clk      (clk),
    .hw_det   (hw_det),
    .sw_kick  (sw_kick),
    .core_rst (core_rst),
    .ready    (ready)
  );

  rstseq_mode_keep #(.MODE_DEF(MODE_DEF)) u_mode (
    .clk     (clk),
    .hw_det  (hw_det),
    .mode_wr (mode_wr),
    .mode_d  (wr_data[MODE_POS]),
    .mode_q  (mode_bit)
  );

  assign line_oe = core_rst ? '0 : oe_req;
endmodule

// File: rtl/rstseq_checks.sv
module rstseq_checks #(
  parameter int         ADDR_W   = 8,
  parameter int         N_OE     = 8,
  parameter logic [7:0] RST_ADDR = 8'h04
) (
  input logic              clk,
  input logic              hw_det,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              core_rst,
  input logic [N_OE-1:0]   line_oe,
  input logic              mode_bit,
  input logic              ready
);
  logic kick;
  assign kick = wr_en && (wr_addr == ADDR_W'(RST_ADDR));

  a_r1_kick_starts_pulse: assert property (@(posedge clk) disable iff (hw_det)
    kick |=> (core_rst && !ready));

  a_r4_outputs_dark: assert property (@(posedge clk) disable iff (hw_det)
    core_rst |-> (line_oe == '0));

  a_r7_no_ready_in_reset: assert property (@(posedge clk) disable iff (hw_det)
    core_rst |-> !ready);

  a_r7_ready_holds: assert property (@(posedge clk) disable iff (hw_det)
    (ready && !kick) |=> ready);

  a_r7_ready_after_settle: assert property (@(posedge clk) disable iff (hw_det)
    $rose(ready) |-> $past(!core_rst));

  a_r8_mode_locked: assert property (@(posedge clk) disable iff (hw_det)
    !ready |=> $stable(mode_bit));
endmodule

bind dual_reset_seq rstseq_checks #(
  .ADDR_W(ADDR_W), .N_OE(N_OE), .RST_ADDR(RST_ADDR)
) u_checks (
  .clk(clk), .hw_det(hw_det), .wr_en(wr_en), .wr_addr(wr_addr),
  .core_rst(core_rst), .line_oe(line_oe), .mode_bit(mode_bit), .ready(ready)
);

// File: tb/test_dual_reset_seq.sv
module test_dual_reset_seq;
  localparam int P = 3;
  localparam int S = 103;
  localparam int W = 3;

  logic       clk = 1'b0;
  logic       hw_rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] oe_req = 8'h5a;
  logic       core_rst;
  logic [7:0] line_oe;
  logic       mode_bit;
  logic       ready;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_reset_seq #(.PULSE_CYC(P), .SETTLE_CYC(S), .HW_MIN_CYC(W)) i_dual_reset_seq (
    .clk(clk), .hw_rst_n(hw_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .oe_req(oe_req), .core_rst(core_rst),
    .line_oe(line_oe), .mode_bit(mode_bit), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Behavioural reference model, stepped on each rising edge.
  int m_d1 = 0, m_d2 = 0, m_low = W, m_ph = 0, m_cnt = 0;
  bit m_rdy = 0, m_mode = 0;

  always @(posedge clk) begin
    bit hw;
    cycles++;
    hw = (m_low >= W);
    if (hw) begin
      m_ph = 0; m_cnt = 0; m_rdy = 0; m_mode = 0;
    end else if (wr_en && wr_addr == 8'h04) begin
      m_ph = 0; m_cnt = 0; m_rdy = 0;
    end else if (m_ph == 0) begin
      if (m_cnt == P - 1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
    end else if (m_ph == 1) begin
      if (m_cnt == S - 1) begin m_ph = 2; m_cnt = 0; m_rdy = 1; end else m_cnt++;
    end else if (wr_en && wr_addr == 8'h20) begin
      m_mode = wr_data[0];
    end
    m_low = (m_d2 == 0) ? ((m_low < W) ? m_low + 1 : W) : 0;
    m_d2 = m_d1;
    m_d1 = hw_rst_n;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(core_rst == (m_ph == 0), "R1 R3 R9 core_rst", core_rst, m_ph == 0);
      chk(ready == m_rdy, "R7 ready", ready, m_rdy);
      chk(mode_bit == m_mode, "R5 R6 R8 R10 mode_bit", mode_bit, m_mode);
      chk(line_oe == ((m_ph == 0) ? 8'h00 : oe_req), "R4 line_oe", line_oe,
          (m_ph == 0) ? 8'h00 : oe_req);
    end
  end

  initial forever begin
    @(posedge clk); #2;
    oe_req = oe_req + 8'h35;
  end

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (8) @(negedge clk);
    cmp_on = 1'b1;
    chk(core_rst == 1'b1, "R3 reset state core_rst", core_rst, 1);
    chk(ready == 1'b0, "R7 reset state ready", ready, 0);
    chk(line_oe == 8'h00, "R4 reset state line_oe", line_oe, 0);
    chk(mode_bit == 1'b0, "R6 reset state mode_bit", mode_bit, 0);
    repeat (4) @(negedge clk);
    hw_rst_n = 1'b1;
    wait_ready();
    chk(ready == 1'b1, "R7 ready after settle", ready, 1);

    do_write(8'h20, 8'h01);
    chk(mode_bit == 1'b1, "R8 mode write when ready", mode_bit, 1);

    do_write(8'h04, 8'hc3);
    chk(core_rst == 1'b1, "R1 sw reset start", core_rst, 1);
    chk(mode_bit == 1'b1, "R5 mode kept by sw reset", mode_bit, 1);
    repeat (2) @(negedge clk);
    chk(core_rst == 1'b1, "R1 pulse still high", core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b0, "R1 pulse ended", core_rst, 0);

    do_write(8'h20, 8'h00);
    chk(mode_bit == 1'b1, "R8 mode write before ready ignored", mode_bit, 1);

    repeat (20) @(negedge clk);
    do_write(8'h04, 8'h00);
    chk(core_rst == 1'b1, "R9 restart from settle", core_rst, 1);
    do_write(8'h04, 8'hff);
    repeat (2) @(negedge clk);
    chk(core_rst == 1'b1, "R9 restart extends pulse", core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b0, "R9 extended pulse ended", core_rst, 0);
    wait_ready();

    do_write(8'h21, 8'h00);
    do_write(8'h05, 8'h00);
    do_write(8'h00, 8'h00);
    chk(mode_bit == 1'b1, "R10 other address mode", mode_bit, 1);
    chk(ready == 1'b1, "R10 other address ready", ready, 1);

    @(negedge clk); hw_rst_n = 1'b0;
    repeat (2) @(negedge clk); hw_rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(core_rst == 1'b0, "R2 short pulse core_rst", core_rst, 0);
    chk(ready == 1'b1, "R2 short pulse ready", ready, 1);
    chk(mode_bit == 1'b1, "R2 short pulse mode", mode_bit, 1);

    @(negedge clk); hw_rst_n = 1'b0;
    repeat (7) @(negedge clk);
    chk(core_rst == 1'b1, "R3 long pulse detected", core_rst, 1);
    chk(mode_bit == 1'b0, "R6 mode cleared by hw reset", mode_bit, 0);
    hw_rst_n = 1'b1;
    wait_ready();
    chk(ready == 1'b1, "R7 ready after hw reset", ready, 1);
    repeat (4) @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule